// File: doc/BRIEF.md
# Transaction ID Qualifier

This block decides, one transaction at a time, whether an observed transaction should be counted as an event. Each transaction carries a source ID, a target ID and a tag bit. Three configuration words steer the decision. A control word holds a master filter enable and one enable per check. A source word holds a match value and a don't-care mask. A target word holds the lower and upper bounds of an inclusive ID window.

The result is a registered pulse that follows the valid strobe by exactly one clock. With the master enable clear, every valid transaction qualifies. With it set, the pulse is the AND of the checks that are switched on. A target window that is malformed is never applied. The block sits in front of an event counter, and the counter increments on each pulse.

Top module: `txn_id_qualifier`

## Requirements
- R1: While and right after the asynchronous reset, `qualify_o` is 0.
- R2: `qualify_o` is high only in the cycle right after a cycle with `txn_valid_i` high, and a valid strobe with no valid in the following cycle produces a pulse of exactly one cycle.
- R3: With control bit 1 (master filter enable) clear, every valid transaction qualifies, whatever the other control bits, filter words, IDs or tag.
- R4: With control bit 1 set and control bits 2, 4 and 5 all clear, every valid transaction qualifies.
- R5: With control bits 1 and 2 set, a transaction qualifies only if its tag bit is 1.
- R6: With control bits 1 and 4 set, the source word holds an 11-bit match value in bits [11:1] and an 11-bit mask in bits [22:12]. The source ID must equal the match value in every bit where the mask is 0, and mask bits that are 1 are don't-care.
- R7: With control bits 1 and 5 set, the target word holds an 11-bit minimum in bits [11:1] and an 11-bit maximum in bits [22:12]. The target ID passes when minimum <= ID <= maximum, inclusive at both ends.
- R8: A target window with maximum 0, or with maximum below minimum, is invalid and is never applied: the target check then passes every ID.
- R9: When several checks are enabled, a transaction qualifies only if every enabled check passes.
- R10: Control bits 0 and 3, source and target word bits outside [22:1], and a disabled check's word have no effect on `qualify_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word: bit 1 master enable, bit 2 tag check, bit 4 source check, bit 5 target check |
| src_flt_i | input | 32 | Source word: match value [11:1], mask [22:12] |
| tgt_flt_i | input | 32 | Target word: minimum [11:1], maximum [22:12] |
| txn_valid_i | input | 1 | Transaction present this cycle |
| src_id_i | input | 11 | Source ID of the transaction |
| tgt_id_i | input | 11 | Target ID of the transaction |
| tag_i | input | 1 | Trace tag of the transaction |
| qualify_o | output | 1 | One-cycle qualify pulse, one cycle after the valid strobe |

## Verification
The assertions assume that the configuration words and transaction fields are defined whenever `txn_valid_i` is high. They also assume that all inputs are held low while reset is active, because every check looks one cycle back at the inputs. The stimulus drives every input on the falling edge and holds everything at zero through reset. It changes a configuration word only in a cycle of its own, so each transaction is judged against a single, stable setting.

// File: rtl/txn_id_qualifier_pkg.sv
package txn_id_qualifier_pkg;
  parameter int unsigned CTL_FILT_BIT = 1;
  parameter int unsigned CTL_TAG_BIT  = 2;
  parameter int unsigned CTL_SRC_BIT  = 4;
  parameter int unsigned CTL_TGT_BIT  = 5;
  parameter int unsigned LO_FIELD_LSB = 1;
  parameter int unsigned HI_FIELD_LSB = 12;

  typedef struct packed {
    logic filt_en;
    logic tag_en;
    logic src_en;
    logic tgt_en;
  } ctl_t;
endpackage

// File: rtl/txn_src_match.sv
module txn_src_match #(
  parameter int unsigned ID_W = 11
) (
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] cmd_i,
  input  logic [ID_W-1:0] mask_i,
  output logic            hit_o
);
  logic [ID_W-1:0] bit_ok;

  for (genvar b = 0; b < ID_W; b++) begin : g_bit
    assign bit_ok[b] = mask_i[b] | (id_i[b] ~^ cmd_i[b]);
  end

  assign hit_o = &bit_ok;
endmodule

// File: rtl/txn_tgt_range.sv
module txn_tgt_range #(
  parameter int unsigned ID_W = 11
) (
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] min_i,
  input  logic [ID_W-1:0] max_i,
  output logic            win_ok_o,
  output logic            hit_o
);
  logic ge_min, le_max;

  assign win_ok_o = (max_i != '0) && (max_i >= min_i);
  assign ge_min   = id_i >= min_i;
  assign le_max   = id_i <= max_i;
  // malformed window is never applied
  assign hit_o    = ~win_ok_o | (ge_min & le_max);
endmodule

// File: rtl/txn_decide.sv
module txn_decide
  import txn_id_qualifier_pkg::*;
(
  input  ctl_t ctl_i,
  input  logic tag_hit_i,
  input  logic src_hit_i,
  input  logic tgt_hit_i,
  output logic pass_o
);
  logic all_hit;

  always_comb begin
    all_hit = 1'b1;
    if (ctl_i.tag_en && !tag_hit_i) all_hit = 1'b0;
    if (ctl_i.src_en && !src_hit_i) all_hit = 1'b0;
    if (ctl_i.tgt_en && !tgt_hit_i) all_hit = 1'b0;
    pass_o = ~ctl_i.filt_en | all_hit;
  end
endmodule

// File: rtl/txn_id_qualifier.sv
module txn_id_qualifier
  import txn_id_qualifier_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned ID_W  = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] ctrl_i,
  input  logic [REG_W-1:0] src_flt_i,
  input  logic [REG_W-1:0] tgt_flt_i,
  input  logic             txn_valid_i,
  input  logic [ID_W-1:0]  src_id_i,
  input  logic [ID_W-1:0]  tgt_id_i,
  input  logic             tag_i,
  output logic             qualify_o
);
  localparam int unsigned LO_MSB = LO_FIELD_LSB + ID_W - 1;
  localparam int unsigned HI_MSB = HI_FIELD_LSB + ID_W - 1;

  ctl_t            ctl;
  logic [ID_W-1:0] src_cmd, src_mask, tgt_min, tgt_max;
  logic            src_hit, tgt_hit, tgt_win_ok, pass;

  assign ctl.filt_en = ctrl_i[CTL_FILT_BIT];
  assign ctl.tag_en  = ctrl_i[CTL_TAG_BIT];
  assign ctl.src_en  = ctrl_i[CTL_SRC_BIT];
  assign ctl.tgt_en  = ctrl_i[CTL_TGT_BIT];

  assign src_cmd  = src_flt_i[LO_MSB:LO_FIELD_LSB];
  assign src_mask = src_flt_i[HI_MSB:HI_FIELD_LSB];
  assign tgt_min  = tgt_flt_i[LO_MSB:LO_FIELD_LSB];
  assign tgt_max  = tgt_flt_i[HI_MSB:HI_FIELD_LSB];

  txn_src_match #(.ID_W(ID_W)) u_src (
    .id_i   (src_id_i),
    .cmd_i  (src_cmd),
    .mask_i (src_mask),
    .hit_o  (src_hit)
  );

  txn_tgt_range #(.ID_W(ID_W)) u_tgt (
    .id_i     (tgt_id_i),
    .min_i    (tgt_min),
    .max_i    (tgt_max),
    .win_ok_o (tgt_win_ok),
    .hit_o    (tgt_hit)
  );

  txn_decide u_dec (
    .ctl_i     (ctl),
    .tag_hit_i (tag_i),
    .src_hit_i (src_hit),
    .tgt_hit_i (tgt_hit),
    .pass_o    (pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qualify_o <= 1'b0;
    else         qualify_o <= txn_valid_i & pass;
  end

  assert_pulse_needs_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qualify_o |-> $past(txn_valid_i));

  assert_bypass_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(txn_valid_i && !ctrl_i[CTL_FILT_BIT]) |-> qualify_o);

  assert_tag_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(txn_valid_i && ctrl_i[CTL_FILT_BIT] && ctrl_i[CTL_TAG_BIT] && !tag_i) |-> !qualify_o);

  assert_src_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(txn_valid_i && ctrl_i[CTL_FILT_BIT] && ctrl_i[CTL_SRC_BIT] && !src_hit) |-> !qualify_o);

  assert_tgt_outside_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(txn_valid_i && ctrl_i[CTL_FILT_BIT] && ctrl_i[CTL_TGT_BIT] && tgt_win_ok &&
          ((tgt_id_i < tgt_min) || (tgt_id_i > tgt_max))) |-> !qualify_o);

  assert_bad_window_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(txn_valid_i && ctrl_i[CTL_FILT_BIT] && ctrl_i[CTL_TGT_BIT] && !ctrl_i[CTL_TAG_BIT] &&
          !ctrl_i[CTL_SRC_BIT] && !tgt_win_ok) |-> qualify_o);
endmodule

// File: tb/txn_id_qualifier_tb_top.sv
module txn_id_qualifier_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl_i = '0, src_flt_i = '0, tgt_flt_i = '0;
  logic        txn_valid_i = 1'b0;
  logic [10:0] src_id_i = '0, tgt_id_i = '0;
  logic        tag_i = 1'b0;
  logic        qualify_o;

  int checks = 0;
  int errors = 0;
  logic  exp_q[$];
  string req_q[$];

  always #10 clk_i = ~clk_i;

  txn_id_qualifier dut_i (
    .clk_i, .rst_ni, .ctrl_i, .src_flt_i, .tgt_flt_i,
    .txn_valid_i, .src_id_i, .tgt_id_i, .tag_i, .qualify_o
  );

  function automatic logic [31:0] pack2(input logic [10:0] lo, input logic [10:0] hi);
    return (32'(hi) << 12) | (32'(lo) << 1);
  endfunction

  function automatic logic model(input logic v, input logic [31:0] c, sf, tf,
                                 input logic [10:0] s, t, input logic g);
    logic ok;
    logic [10:0] cmd, msk, mn, mx;
    cmd = sf[11:1]; msk = sf[22:12]; mn = tf[11:1]; mx = tf[22:12];
    ok = 1'b1;
    if (!v) return 1'b0;
    if (!c[1]) return 1'b1;
    if (c[2] && !g) ok = 1'b0;
    if (c[4] && ((s & ~msk) != (cmd & ~msk))) ok = 1'b0;
    if (c[5] && (mx != 0) && (mx >= mn) && ((t < mn) || (t > mx))) ok = 1'b0;
    return ok;
  endfunction

  task automatic cfg(input logic [31:0] c, sf, tf);
    @(negedge clk_i);
    ctrl_i = c; src_flt_i = sf; tgt_flt_i = tf; txn_valid_i = 1'b0;
    exp_q.push_back(1'b0); req_q.push_back("R2");
  endtask

  task automatic step(input logic v, input logic [10:0] s, t, input logic g, input string req);
    @(negedge clk_i);
    txn_valid_i = v; src_id_i = s; tgt_id_i = t; tag_i = g;
    exp_q.push_back(model(v, ctrl_i, src_flt_i, tgt_flt_i, s, t, g));
    req_q.push_back(req);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        logic e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if (qualify_o !== e) begin
          errors++;
          $display("FAIL %s qualify_o actual %b expected %b", r, qualify_o, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog run did not finish actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk_i);
    checks++;
    if (qualify_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset qualify_o actual %b expected 0", qualify_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (qualify_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset qualify_o actual %b expected 0", qualify_o);
    end

    // R3: master off, every check bit set, hostile words
    cfg(32'h0000_0034, pack2(11'h7FF, 11'h000), pack2(11'd5, 11'd6));
    step(1, 11'h000, 11'd100, 0, "R3");
    step(1, 11'h123, 11'd0,   0, "R3");
    // R2: single pulse, idle cycles stay low
    step(0, 11'h000, 11'd0, 1, "R2");
    step(1, 11'h001, 11'd1, 1, "R2");
    step(0, 11'h001, 11'd1, 1, "R2");
    step(0, 11'h001, 11'd1, 1, "R2");

    // R4: master on, no checks
    cfg(32'h0000_0002, pack2(11'h7FF, 11'h000), pack2(11'd5, 11'd6));
    step(1, 11'h000, 11'd100, 0, "R4");
    step(1, 11'h3AB, 11'd2047, 0, "R4");

    // R5: tag check
    cfg(32'h0000_0006, '0, '0);
    step(1, 11'h010, 11'd10, 0, "R5");
    step(1, 11'h010, 11'd10, 1, "R5");
    step(1, 11'h011, 11'd11, 0, "R5");

    // R6: masked source match, low nibble don't-care
    cfg(32'h0000_0012, pack2(11'h155, 11'h00F), '0);
    step(1, 11'h15A, 11'd0, 0, "R6");
    step(1, 11'h150, 11'd0, 0, "R6");
    step(1, 11'h055, 11'd0, 0, "R6");
    step(1, 11'h355, 11'd0, 0, "R6");
    cfg(32'h0000_0012, pack2(11'h155, 11'h000), '0);
    step(1, 11'h155, 11'd0, 0, "R6");
    step(1, 11'h154, 11'd0, 0, "R6");

    // R7: inclusive window 10..20
    cfg(32'h0000_0022, '0, pack2(11'd10, 11'd20));
    step(1, 11'h0, 11'd9,  0, "R7");
    step(1, 11'h0, 11'd10, 0, "R7");
    step(1, 11'h0, 11'd15, 0, "R7");
    step(1, 11'h0, 11'd20, 0, "R7");
    step(1, 11'h0, 11'd21, 0, "R7");
    cfg(32'h0000_0022, '0, pack2(11'd0, 11'd2047));
    step(1, 11'h0, 11'd0,    0, "R7");
    step(1, 11'h0, 11'd2047, 0, "R7");

    // R8: malformed windows are not applied
    cfg(32'h0000_0022, '0, pack2(11'd0, 11'd0));
    step(1, 11'h0, 11'd500, 0, "R8");
    cfg(32'h0000_0022, '0, pack2(11'd8, 11'd5));
    step(1, 11'h0, 11'd6,  0, "R8");
    step(1, 11'h0, 11'd99, 0, "R8");
    cfg(32'h0000_0022, '0, pack2(11'd7, 11'd7));
    step(1, 11'h0, 11'd7, 0, "R8");
    step(1, 11'h0, 11'd8, 0, "R8");

    // R9: all three checks combined
    cfg(32'h0000_0036, pack2(11'h0A0, 11'h00F), pack2(11'd100, 11'd200));
    step(1, 11'h0A3, 11'd150, 1, "R9");
    step(1, 11'h0A3, 11'd150, 0, "R9");
    step(1, 11'h1A3, 11'd150, 1, "R9");
    step(1, 11'h0A3, 11'd201, 1, "R9");
    step(1, 11'h0AF, 11'd100, 1, "R9");

    // R10: stray control and word bits, disabled check words
    cfg(32'hFFFF_FFC9, pack2(11'h7FF, 11'h000), pack2(11'd5, 11'd6));
    step(1, 11'h000, 11'd100, 0, "R10");
    cfg(32'h0000_000B, pack2(11'h7FF, 11'h000), pack2(11'd5, 11'd6));
    step(1, 11'h000, 11'd100, 0, "R10");
    cfg(32'h0000_0022, 32'h0, pack2(11'd10, 11'd20) | 32'hFF80_0001);
    step(1, 11'h0, 11'd15, 0, "R10");
    step(1, 11'h0, 11'd25, 0, "R10");
    cfg(32'h0000_0012, pack2(11'h155, 11'h000) | 32'hFF80_0001, '0);
    step(1, 11'h155, 11'd0, 0, "R10");
    step(1, 11'h154, 11'd0, 0, "R10");

    step(0, 11'h0, 11'd0, 0, "R2");
    repeat (3) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule